// File: doc/BRIEF.md
# Predicated Prefetch Address Walker

The walker accepts one decoded vector prefetch request at a time and turns it into a stream of single-address prefetch requests, one for each active element of a vector of 16-bit elements. The element count is the vector length in bits divided by 16. The predicate supplies two bits per element, and an element takes part only when the lower bit of its pair is set. For every active element the walker emits the address `base + ((index + e) << 1)`, computed modulo 2^64. It does this without changing the index operand. Each request also carries a read/write hint, a cache level and a streaming flag, all decoded from the 4-bit operation field of the instruction word.

The request is offered on a valid/ready start handshake. The start port is ready only while the walker is idle. Prefetch requests leave through a registered valid/ready port with one request per cycle at most. Inactive elements cost no cycles. A single-cycle completion pulse follows the last request. An index register field of 31 is an illegal encoding: the walker reports it with an undefined-instruction pulse and issues nothing for that request.

Top module: `vpf_walker`

## Requirements
- R1: Only elements e < vlen/16 are considered; predicate bits of elements at or above that count have no effect (vlen is a multiple of 128 and at most MAX_VL).
- R2: Element e is active exactly when predicate bit 2*e is 1; the odd predicate bits have no effect.
- R3: The address of active element e is base + ((index + e) << 1) modulo 2^64, and the base comes from the base register value when instruction bits 9:5 are not 31.
- R4: When instruction bits 9:5 equal 31, the stack pointer value replaces the base register value.
- R5: When instruction bits 20:16 equal 31, undef and done both pulse in the cycle after the request is accepted, and no prefetch request is issued.
- R6: Each request carries level = op[2:1], stream = op[0], and write = op[3] (0 = read hint), where op is instruction bits 3:0.
- R7: Requests are emitted in ascending element order. With ready held high, the first request appears two cycles after acceptance and the requests after it follow back-to-back, so that done appears n+2 cycles after acceptance for n active elements.
- R8: While req_valid is high and req_ready is low, req_valid stays high and the address and hint fields stay stable.
- R9: A request with no active element issues no request, and done pulses two cycles after acceptance.
- R10: done is a one-cycle pulse in a cycle with no request pending, start_ready is low from acceptance until done, and it is high again when done is shown.
- R11: After reset, req_valid, done and undef are low and start_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | A request is offered |
| start_ready | output | 1 | Walker is idle and accepts a request |
| instr | input | 32 | Instruction word (index field 20:16, base field 9:5, operation 3:0) |
| base_val | input | 64 | Value of the base general register |
| index_val | input | 64 | Value of the index register |
| sp_val | input | 64 | Stack pointer value |
| pred | input | MAX_VL/8 | Predicate, two bits per element |
| vlen | input | clog2(MAX_VL)+1 | Vector length in bits |
| req_valid | output | 1 | Prefetch request valid |
| req_ready | input | 1 | Consumer takes the request |
| req_addr | output | 64 | Prefetch address |
| req_write | output | 1 | 1 = write hint, 0 = read hint |
| req_level | output | 2 | Target cache level |
| req_stream | output | 1 | Streaming hint |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | One-cycle illegal-encoding pulse |

## Verification
A corrupted element cursor shows up on the very next handshake: the address is off by a multiple of two, or an element is repeated or skipped. A lost or extra active lane changes the request count and moves done away from its n+2 slot, so the error shows by the end of that request at the latest. A stall that drops or alters the held request shows in the cycle after ready returns. A wrong base selection or a wrong wrap shows on the first address of the affected vector.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
  localparam int unsigned REG_SP_CODE = 31;

  typedef struct packed {
    logic       write;
    logic [1:0] level;
    logic       stream;
  } pf_hint_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1
  } walk_state_t;
endpackage

// File: rtl/vpf_decode.sv
module vpf_decode
  import vpf_pkg::*;
(
  input  logic [31:0] instr,
  output logic        idx_illegal,
  output logic        base_is_sp,
  output pf_hint_t    hint
);
  logic [4:0] idx_field;
  logic [4:0] base_field;
  logic [3:0] op_field;
  logic       unused_fields;

  assign idx_field  = instr[20:16];
  assign base_field = instr[9:5];
  assign op_field   = instr[3:0];

  assign idx_illegal = (idx_field == 5'(REG_SP_CODE));
  assign base_is_sp  = (base_field == 5'(REG_SP_CODE));

  always_comb begin
    hint.write  = op_field[3];
    hint.level  = op_field[2:1];
    hint.stream = op_field[0];
  end

  assign unused_fields = ^{instr[31:21], instr[15:10], instr[4]};
endmodule

// File: rtl/vpf_lane_pick.sv
module vpf_lane_pick #(
  parameter int NELEM = 32,
  localparam int EW = $clog2(NELEM) + 1
) (
  input  logic [NELEM-1:0] lanes,
  input  logic [EW-1:0]    cursor,
  output logic             found,
  output logic [EW-1:0]    next_lane
);
  logic [NELEM-1:0] eligible;

  for (genvar i = 0; i < NELEM; i++) begin : g_mask
    assign eligible[i] = lanes[i] && (EW'(i) >= cursor);
  end

  always_comb begin
    found     = 1'b0;
    next_lane = '0;
    for (int i = NELEM - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        found     = 1'b1;
        next_lane = EW'(i);
      end
    end
  end
endmodule

// File: rtl/vpf_addr_gen.sv
module vpf_addr_gen #(
  parameter int AW = 64,
  parameter int EW = 6
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [EW-1:0] elem,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] run_idx;

  assign run_idx = index + AW'(elem);
  assign addr    = base + (run_idx << 1);
endmodule

// File: rtl/vpf_walker.sv
module vpf_walker
  import vpf_pkg::*;
#(
  parameter int MAX_VL = 512,
  parameter int AW = 64,
  localparam int PRED_W = MAX_VL / 8,
  localparam int VLW = $clog2(MAX_VL) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [31:0]       instr,
  input  logic [AW-1:0]     base_val,
  input  logic [AW-1:0]     index_val,
  input  logic [AW-1:0]     sp_val,
  input  logic [PRED_W-1:0] pred,
  input  logic [VLW-1:0]    vlen,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  output logic              req_write,
  output logic [1:0]        req_level,
  output logic              req_stream,
  output logic              done,
  output logic              undef
);
  localparam int NELEM = MAX_VL / 16;
  localparam int EW = $clog2(NELEM) + 1;
  localparam logic [PRED_W-1:0] ODD_BITS = {NELEM{2'b10}};

  walk_state_t       state_q;
  logic [NELEM-1:0]  lanes_q;
  logic [NELEM-1:0]  lanes_in;
  logic [EW-1:0]     cursor_q;
  logic [EW-1:0]     elem_cnt;
  logic [AW-1:0]     base_q;
  logic [AW-1:0]     index_q;
  pf_hint_t          hint_q;
  pf_hint_t          hint_in;
  logic              idx_illegal;
  logic              base_is_sp;
  logic              any_active;
  logic              accept;
  logic              slot_free;
  logic              pick_found;
  logic [EW-1:0]     pick_lane;
  logic [AW-1:0]     next_addr;
  logic              unused_top;

  vpf_decode u_dec (
    .instr      (instr),
    .idx_illegal(idx_illegal),
    .base_is_sp (base_is_sp),
    .hint       (hint_in)
  );

  assign elem_cnt = EW'(vlen >> 4);

  for (genvar e = 0; e < NELEM; e++) begin : g_lane
    assign lanes_in[e] = pred[2*e] && (EW'(e) < elem_cnt);
  end

  assign any_active = |lanes_in;
  assign unused_top = ^(pred & ODD_BITS);

  vpf_lane_pick #(.NELEM(NELEM)) u_pick (
    .lanes    (lanes_q),
    .cursor   (cursor_q),
    .found    (pick_found),
    .next_lane(pick_lane)
  );

  vpf_addr_gen #(.AW(AW), .EW(EW)) u_agen (
    .base (base_q),
    .index(index_q),
    .elem (pick_lane),
    .addr (next_addr)
  );

  assign start_ready = (state_q == ST_IDLE);
  assign accept      = start_valid && start_ready;
  assign slot_free   = !req_valid || req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      lanes_q    <= '0;
      cursor_q   <= '0;
      base_q     <= '0;
      index_q    <= '0;
      hint_q     <= '0;
      req_valid  <= 1'b0;
      req_addr   <= '0;
      req_write  <= 1'b0;
      req_level  <= 2'd0;
      req_stream <= 1'b0;
      done       <= 1'b0;
      undef      <= 1'b0;
    end else begin
      done  <= 1'b0;
      undef <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (idx_illegal) begin
              done  <= 1'b1;
              undef <= 1'b1;
            end else begin
              state_q  <= ST_RUN;
              lanes_q  <= lanes_in;
              cursor_q <= '0;
              hint_q   <= hint_in;
              if (any_active) begin
                base_q  <= base_is_sp ? sp_val : base_val;
                index_q <= index_val;
              end
            end
          end
        end
        ST_RUN: begin
          if (slot_free) begin
            if (pick_found) begin
              req_valid  <= 1'b1;
              req_addr   <= next_addr;
              req_write  <= hint_q.write;
              req_level  <= hint_q.level;
              req_stream <= hint_q.stream;
              cursor_q   <= pick_lane + EW'(1);
            end else begin
              req_valid <= 1'b0;
              done      <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vpf_walker_chk.sv
module vpf_walker_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          start_ready,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          req_write,
  input logic [1:0]    req_level,
  input logic          req_stream,
  input logic          done,
  input logic          undef
);
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_valid);

  a_r8_hold_payload: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> ($stable(req_addr) && $stable(req_write)
                                   && $stable(req_level) && $stable(req_stream)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!req_valid && start_ready));

  a_r10_busy_no_start: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !start_ready);

  a_r5_undef_with_done: assert property (@(posedge clk) disable iff (rst)
    undef |-> done);
endmodule

bind vpf_walker vpf_walker_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_ready(start_ready),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_write  (req_write),
  .req_level  (req_level),
  .req_stream (req_stream),
  .done       (done),
  .undef      (undef)
);

// File: tb/sim_vpf_walker.sv
`timescale 1ns/1ps
module sim_vpf_walker;
  localparam int MAX_VL = 512;
  localparam int PW = MAX_VL / 8;
  localparam int VLW = $clog2(MAX_VL) + 1;
  localparam int NV = 8;

  function automatic logic [31:0] mk(input logic [4:0] rm, input logic [4:0] rn,
                                     input logic [3:0] op);
    return {11'b10000100100, rm, 3'b110, 3'd0, rn, 1'b0, op};
  endfunction

  localparam logic [31:0] T_INSTR [NV] = '{
    mk(5'd2, 5'd3, 4'b0000), mk(5'd4, 5'd31, 4'b1011), mk(5'd1, 5'd7, 4'b0110),
    mk(5'd2, 5'd3, 4'b0001), mk(5'd0, 5'd1, 4'b1000), mk(5'd9, 5'd8, 4'b0100),
    mk(5'd31, 5'd3, 4'b0000), mk(5'd5, 5'd6, 4'b1101)};
  localparam logic [63:0] T_BASE [NV] = '{
    64'h1000, 64'hDEAD, 64'hFFFF_FFFF_FFFF_FFF0, 64'h2000,
    64'h4000_0000, 64'h100, 64'h3000, 64'h0123_4567_89AB_CDE0};
  localparam logic [63:0] T_INDEX [NV] = '{
    64'h0, 64'h5, 64'h6, 64'h0, 64'h10, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 64'h7};
  localparam logic [63:0] T_SP [NV] = '{
    64'h0, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0};
  localparam logic [63:0] T_PRED [NV] = '{
    64'h5555_5555_5555_5555, 64'h0000_0000_0000_0011, 64'h0000_0000_0000_5555,
    64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 64'h4000_0000_0000_0001,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001};
  localparam int T_VLEN [NV] = '{512, 256, 128, 512, 128, 512, 512, 512};
  localparam bit T_TOGGLE [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_valid = 1'b0;
  logic start_ready;
  logic [31:0] instr = '0;
  logic [63:0] base_val = '0, index_val = '0, sp_val = '0;
  logic [PW-1:0] pred = '0;
  logic [VLW-1:0] vlen = '0;
  logic req_valid, req_ready = 1'b1;
  logic [63:0] req_addr;
  logic req_write, req_stream, done, undef;
  logic [1:0] req_level;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  vpf_walker #(.MAX_VL(MAX_VL)) u0 (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
    .instr(instr), .base_val(base_val), .index_val(index_val), .sp_val(sp_val),
    .pred(pred), .vlen(vlen), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_level(req_level),
    .req_stream(req_stream), .done(done), .undef(undef));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_vec(input int i);
    logic [63:0] exp_addr [32];
    logic [63:0] base_sel;
    int n = 0;
    int got = 0;
    int ne;
    bit bad_idx, seen_done, stall_prev;
    logic [63:0] prev_addr;
    bad_idx  = (T_INSTR[i][20:16] == 5'd31);
    base_sel = (T_INSTR[i][9:5] == 5'd31) ? T_SP[i] : T_BASE[i];
    ne = T_VLEN[i] / 16;
    if (!bad_idx)
      for (int e = 0; e < ne; e++)
        if (T_PRED[i][2*e]) begin
          exp_addr[n] = base_sel + ((T_INDEX[i] + 64'(e)) << 1);
          n++;
        end
    @(negedge clk);
    instr = T_INSTR[i]; base_val = T_BASE[i]; index_val = T_INDEX[i];
    sp_val = T_SP[i]; pred = T_PRED[i]; vlen = VLW'(T_VLEN[i]);
    start_valid = 1'b1;
    stall_prev = 1'b0;
    seen_done = 1'b0;
    prev_addr = '0;
    for (int c = 1; c < 300 && !seen_done; c++) begin
      @(negedge clk);
      start_valid = 1'b0;
      if (stall_prev)
        check(req_valid && req_addr == prev_addr, "R8 stall hold", req_addr, prev_addr);
      if (c == 1 && !bad_idx)
        check(start_ready == 1'b0, "R10 busy", 64'(start_ready), 64'd0);
      if (undef || done) begin
        seen_done = done;
        check(undef == bad_idx, "R5 undef flag", 64'(undef), 64'(bad_idx));
      end
      if (done) begin
        check(got == n, "R1/R2/R9 request count", 64'(got), 64'(n));
        check(start_ready == 1'b1, "R10 idle at done", 64'(start_ready), 64'd1);
        if (bad_idx)
          check(c == 1, "R5 undef timing", 64'(c), 64'd1);
        else if (!T_TOGGLE[i])
          check(c == n + 2, "R7/R9 done timing", 64'(c), 64'(n + 2));
      end
      req_ready = T_TOGGLE[i] ? (c % 2 == 0) : 1'b1;
      if (req_valid && req_ready) begin
        if (got >= n) check(1'b0, "R7 extra request", req_addr, 64'd0);
        else begin
          check(req_addr == exp_addr[got], "R3/R4 address order", req_addr, exp_addr[got]);
          check({req_write, req_level, req_stream} == T_INSTR[i][3:0], "R6 hint",
                64'({req_write, req_level, req_stream}), 64'(T_INSTR[i][3:0]));
        end
        got++;
      end
      stall_prev = req_valid && !req_ready;
      prev_addr  = req_addr;
    end
    check(seen_done, "R10 done seen", 64'(seen_done), 64'd1);
    req_ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(req_valid == 1'b0, "R11 reset valid", 64'(req_valid), 64'd0);
    check(done == 1'b0 && undef == 1'b0, "R11 reset pulses", 64'({done, undef}), 64'd0);
    check(start_ready == 1'b1, "R11 reset ready", 64'(start_ready), 64'd1);
    for (int i = 0; i < NV; i++) run_vec(i);
    // R2: odd bits only, R1: lanes beyond vlen/16 set but count limited
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0 && done == 1'b0, "R10 quiet after run",
          64'({req_valid, done}), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule